// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is a memory-mapped SPI master that sits on a simple word-addressed write/read bus. Software places a word in the transmit register and then writes the control register once. That single write carries both the bit length and a start bit. Software then polls the idle flag in the status register and reads the received word. The block drives a serial clock that idles low, shifts the most significant bit first in SPI mode 0, and drives one active-low select line per attached slave.

The serial clock period is given directly in system-clock cycles by a divider register. The divider register exists only when the `HAS_DIV` parameter is set; without it, a fixed period parameter applies. A loopback bit feeds the serial output straight back into the receive path, so software can test the block without a slave attached. The longest word is capped by `MAX_BITS`, which can be set anywhere from 1 to 32.

Top module: `regspi_master`

## Requirements
- R1: Registers are word addressed: control at 0, status at 1, transmit at 2, receive at 3, select at 4, loopback at 5 and divider at 6. After reset the status idle bit (bit 0) reads 1, the receive register reads 0, `sclk` is low and every `cs_n` line is high.
- R2: A write to the control register with bit 0 set starts one transfer while the block is idle. The transfer lasts N×P system cycles, where N is the length and P is the period. The status idle bit reads 0 during the transfer and returns to 1 when it ends.
- R3: `mosi` carries the transmit word's N low bits, most significant bit first. `sclk` idles low, `mosi` holds steady while `sclk` is high, and `miso` is sampled on each rising `sclk` edge.
- R4: After a transfer of N bits, the receive register holds the N sampled bits, right-aligned, with the first sampled bit as bit N-1.
- R5: The length field occupies control bits [15:8]. A length of 0, or any length above `MAX_BITS`, is treated as `MAX_BITS`. The control register reads back the length that was accepted.
- R6: The select register has one bit per slave. Each `cs_n` output is the inverse of its register bit, so writing 0 raises every select line.
- R7: When loopback register bit 0 is 1, the receive path takes `mosi` in place of the `miso` pin, and the received word equals the transmitted word.
- R8: The divider register sets the `sclk` period P in system cycles, with `sclk` low for floor(P/2) of them. Values 0 and 1 act as 2. The period is captured at start.
- R9: Any control write made during a transfer is ignored. The running transfer keeps its length and timing, and the accepted length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low slave selects |

## Verification
A bench-side slave model returns a word that differs from the transmitted one. A swapped or shifted receive path therefore shows up in the receive register, and a monitor reassembles `mosi` to check the bit order. The transfers cover full-length words, a short length, and two out-of-range lengths, so length clamping and right alignment are told apart. Several divider values, including 0, let the measured transfer length expose off-by-one errors in the period counter. A loopback transfer and a control write issued mid-transfer separate the internal feedback path and the busy guard from normal operation.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
   localparam int REG_AW  = 3;
   localparam int BUS_W   = 32;
   localparam int LEN_LSB = 8;
   localparam int LEN_FW  = 8;
   localparam int CNT_W   = 6;

   typedef enum logic [REG_AW-1:0] {
      A_CTRL = 3'd0,
      A_STAT = 3'd1,
      A_TXD  = 3'd2,
      A_RXD  = 3'd3,
      A_CSEL = 3'd4,
      A_LOOP = 3'd5,
      A_DIV  = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/regspi_regs.sv
module regspi_regs
   import regspi_pkg::*;
#(
   parameter int MAX_BITS = 8,
   parameter int NUM_CS   = 1,
   parameter int HAS_DIV  = 1,
   parameter int DIV_W    = 16,
   parameter int DEF_DIV  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic [REG_AW-1:0]   rd_addr,
   output logic [BUS_W-1:0]    rd_data,
   input  logic                busy,
   input  logic [MAX_BITS-1:0] rx_word,
   output logic                start,
   output logic [CNT_W-1:0]    start_len,
   output logic [MAX_BITS-1:0] tx_word,
   output logic [NUM_CS-1:0]   cs_q,
   output logic                loop_q,
   output logic [DIV_W-1:0]    div_eff
);
   localparam int DEF_CLAMP = (DEF_DIV < 2) ? 2 : DEF_DIV;

   logic [LEN_FW-1:0] len_fld;
   logic [CNT_W-1:0]  ctl_len_q;
   logic              ctl_wr;
   logic [BUS_W-1:0]  div_rd;

   assign len_fld   = wr_data[LEN_LSB +: LEN_FW];
   assign ctl_wr    = wr_en && (wr_addr == A_CTRL) && !busy;
   assign start     = ctl_wr && wr_data[0];
   assign start_len = (len_fld == '0 || len_fld > LEN_FW'(MAX_BITS))
                      ? CNT_W'(MAX_BITS) : len_fld[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_len_q <= '0;
         tx_word   <= '0;
         cs_q      <= '0;
         loop_q    <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: if (!busy) ctl_len_q <= start_len;
            A_TXD:  tx_word <= wr_data[MAX_BITS-1:0];
            A_CSEL: cs_q    <= wr_data[NUM_CS-1:0];
            A_LOOP: loop_q  <= wr_data[0];
            default: ;
         endcase
      end
   end

   generate
      if (HAS_DIV != 0) begin : g_div_reg
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          div_q <= DIV_W'(DEF_DIV);
            else if (wr_en && wr_addr == A_DIV)  div_q <= wr_data[DIV_W-1:0];
         end
         assign div_eff = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;
         assign div_rd  = BUS_W'(div_q);
      end else begin : g_div_fixed
         assign div_eff = DIV_W'(DEF_CLAMP);
         assign div_rd  = '0;
      end
   endgenerate

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = BUS_W'(ctl_len_q) << LEN_LSB;
         A_STAT:  rd_data = {{(BUS_W-1){1'b0}}, ~busy};
         A_TXD:   rd_data = BUS_W'(tx_word);
         A_RXD:   rd_data = BUS_W'(rx_word);
         A_CSEL:  rd_data = BUS_W'(cs_q);
         A_LOOP:  rd_data = {{(BUS_W-1){1'b0}}, loop_q};
         A_DIV:   rd_data = div_rd;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/regspi_clkgen.sv
module regspi_clkgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] period,
   input  logic             run,
   output logic             rise,
   output logic             last
);
   logic [DIV_W-1:0] per_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] half;

   assign half = per_q >> 1;
   assign rise = run && (cnt_q == half - 1'b1);
   assign last = run && (cnt_q == per_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= DIV_W'(2);
         cnt_q <= '0;
      end else begin
         if (start) per_q <= period;
         if (!run || last) cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/regspi_shifter.sv
module regspi_shifter
   import regspi_pkg::*;
#(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CNT_W-1:0]    start_len,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                miso_in,
   input  logic                rise,
   input  logic                last,
   output logic                busy,
   output logic                sclk,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_word,
   output logic [CNT_W-1:0]    bit_cnt,
   output logic [CNT_W-1:0]    len_q
);
   logic [MAX_BITS-1:0] shreg;

   assign mosi = busy & shreg[MAX_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         shreg   <= '0;
         rx_word <= '0;
         bit_cnt <= '0;
         len_q   <= CNT_W'(1);
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            shreg   <= tx_word << (MAX_BITS - int'(start_len));
            rx_word <= '0;
            bit_cnt <= '0;
            len_q   <= start_len;
         end
      end else begin
         if (rise) begin
            sclk    <= 1'b1;
            rx_word <= (rx_word << 1) | MAX_BITS'(miso_in);
         end
         if (last) begin
            sclk <= 1'b0;
            if (bit_cnt == len_q - 1'b1) begin
               busy <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               shreg   <= shreg << 1;
            end
         end
      end
   end
endmodule

// File: rtl/regspi_master.sv
module regspi_master
   import regspi_pkg::*;
#(
   parameter int MAX_BITS = 8,
   parameter int NUM_CS   = 1,
   parameter int HAS_DIV  = 1,
   parameter int DIV_W    = 16,
   parameter int DEF_DIV  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);
   generate
      if (MAX_BITS < 1 || MAX_BITS > 32) begin : g_bad_bits
         $error("MAX_BITS must lie in 1..32");
      end
      if (NUM_CS < 1 || NUM_CS > 32) begin : g_bad_cs
         $error("NUM_CS must lie in 1..32");
      end
      if (DIV_W < 2 || DIV_W > 32) begin : g_bad_div
         $error("DIV_W must lie in 2..32");
      end
   endgenerate

   logic                busy;
   logic                start;
   logic [CNT_W-1:0]    start_len;
   logic [MAX_BITS-1:0] tx_word;
   logic [MAX_BITS-1:0] rx_word;
   logic [NUM_CS-1:0]   cs_q;
   logic                loop_q;
   logic [DIV_W-1:0]    div_eff;
   logic                rise;
   logic                last;
   logic                miso_in;
   logic [CNT_W-1:0]    bit_cnt;
   logic [CNT_W-1:0]    len_q;

   assign cs_n    = ~cs_q;
   assign miso_in = loop_q ? mosi : miso;

   regspi_regs #(
      .MAX_BITS(MAX_BITS), .NUM_CS(NUM_CS), .HAS_DIV(HAS_DIV),
      .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .rx_word(rx_word), .start(start), .start_len(start_len),
      .tx_word(tx_word), .cs_q(cs_q), .loop_q(loop_q), .div_eff(div_eff)
   );

   regspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .start(start), .period(div_eff),
      .run(busy), .rise(rise), .last(last)
   );

   regspi_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
      .tx_word(tx_word), .miso_in(miso_in), .rise(rise), .last(last),
      .busy(busy), .sclk(sclk), .mosi(mosi), .rx_word(rx_word),
      .bit_cnt(bit_cnt), .len_q(len_q)
   );
endmodule

// File: rtl/regspi_chk.sv
module regspi_chk
   import regspi_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             sclk,
   input logic             mosi,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic [31:0]      wr_data,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [CNT_W-1:0] len_q
);
   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && wr_data[0] && !busy) |=> busy);

   p_end_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(sclk));

   p_bits_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (len_q != '0 && bit_cnt < len_q));

   p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(len_q));
endmodule

bind regspi_master regspi_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .mosi(mosi),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .bit_cnt(bit_cnt), .len_q(len_q)
);

// File: tb/regspi_master_tb.sv
module regspi_master_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        sclk, mosi, miso;
   logic [0:0]  cs_n;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;

   // slave model
   logic [31:0] slv_word = '0;
   int          slv_len = 8;
   int          slv_idx = 0;
   assign miso = (slv_idx < slv_len) ? slv_word[slv_len-1-slv_idx] : 1'b0;
   always @(negedge sclk) slv_idx = slv_idx + 1;

   typedef struct { logic [31:0] word; int len; string tag; } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   regspi_master u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   // monitor: rebuilds mosi words and compares against the expected queue
   initial begin
      logic [31:0] cap;
      int n;
      cap = '0; n = 0;
      forever begin
         @(posedge sclk);
         cap = (cap << 1) | 32'(mosi);
         n++;
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R3 unexpected sclk edge actual=%0d expected=0", n);
            n = 0; cap = '0;
         end else if (n == exp_q[0].len) begin
            check({"R3 mosi order ", exp_q[0].tag}, cap, exp_q[0].word);
            void'(exp_q.pop_front());
            n = 0; cap = '0;
         end
      end
   end

   // one transfer: write ctrl, count cycles until idle, read receive word
   task automatic xfer(input string tag, input logic [31:0] tx, input logic [31:0] slv,
                       input int len_fld, input int eff_len, input int period,
                       input logic [31:0] exp_rx, input bit poke);
      logic [31:0] d;
      int cnt;
      exp_t e;
      e.word = tx & ((32'd1 << eff_len) - 1); e.len = eff_len; e.tag = tag;
      exp_q.push_back(e);
      reg_wr(3'd2, tx);
      slv_word = slv; slv_len = eff_len; slv_idx = 0;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = (32'(len_fld) << 8) | 32'd1;
      rd_addr = 3'd1;
      cnt = 0;
      do begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         wr_en = 1'b0;
         if (poke && cnt == 3) begin
            wr_en = 1'b1; wr_addr = 3'd0; wr_data = (32'd2 << 8) | 32'd1;
         end
         rd_addr = 3'd1;
         #1;
         if (cnt == 2 && !poke) check({"R2 busy status ", tag}, rd_data & 32'd1, 32'd0);
      end while (rd_data[0] == 1'b0 && cnt < 5000);
      wr_en = 1'b0;
      check({"R2 R8 transfer cycles ", tag}, 32'(cnt - 1), 32'(eff_len * period));
      reg_rd(3'd3, d);
      check({"R4 receive word ", tag}, d, exp_rx);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R3 missing bits %s actual=%0d expected=0", tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      reg_rd(3'd1, d); check("R1 status idle after reset", d & 32'd1, 32'd1);
      reg_rd(3'd3, d); check("R1 receive zero after reset", d, 32'd0);
      check("R1 sclk low after reset", 32'(sclk), 32'd0);
      check("R1 cs_n high after reset", 32'(cs_n), 32'd1);
      // R6 select
      reg_wr(3'd4, 32'd1);
      #1 check("R6 select asserted", 32'(cs_n), 32'd0);
      // R2 R3 R4 full length, default period 4
      xfer("full8", 32'hA5, 32'h3C, 8, 8, 4, 32'h3C, 0);
      // R5 short length right aligned, period 5
      reg_wr(3'd6, 32'd5);
      xfer("len4", 32'h9, 32'h6, 4, 4, 5, 32'h6, 0);
      reg_rd(3'd0, d); check("R5 ctrl readback len4", d, 32'h0400);
      // R5 zero length -> max
      xfer("len0", 32'hF0, 32'h81, 0, 8, 5, 32'h81, 0);
      reg_rd(3'd0, d); check("R5 ctrl readback clamp0", d, 32'h0800);
      // R5 over length -> max, R8 period 3
      reg_wr(3'd6, 32'd3);
      xfer("len12", 32'hC3, 32'h5E, 12, 8, 3, 32'h5E, 0);
      // R8 divider 0 treated as 2
      reg_wr(3'd6, 32'd0);
      xfer("div0", 32'h17, 32'hE8, 8, 8, 2, 32'hE8, 0);
      // R7 loopback
      reg_wr(3'd6, 32'd4);
      reg_wr(3'd5, 32'd1);
      xfer("loop", 32'h5A, 32'hFF, 8, 8, 4, 32'h5A, 0);
      reg_wr(3'd5, 32'd0);
      // R9 control write during transfer ignored
      xfer("poke", 32'h6D, 32'h92, 8, 8, 4, 32'h92, 1);
      reg_rd(3'd0, d); check("R9 ctrl length unchanged", d, 32'h0800);
      reg_rd(3'd1, d); check("R9 no restart after poke", d & 32'd1, 32'd1);
      // R6 deassert
      reg_wr(3'd4, 32'd0);
      #1 check("R6 select released", 32'(cs_n), 32'd1);
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end
endmodule